// File: doc/BRIEF.md
# Halfword and Signed-Byte Transfer Unit

This block carries out the halfword and signed-byte load/store instructions of a 32-bit RISC core. It receives the instruction's fields already decoded: the base and data register indices, a load/store flag, the indexing mode, a writeback flag, a two-bit transfer type and an offset that has already been resolved to a signed 32-bit value. Alongside these come the instruction address and the two register-file read values. From this it computes the transfer address, performs a single access on a request/ready data port, and sign- or zero-extends loaded data. It then writes the loaded value and the updated base back through a single register-file write port, one register per cycle.

An instruction is offered by pulsing `start` while `busy` is low. The unit rejects encodings it cannot execute, and it flags a load into the program counter so that the pipeline can refetch. When the program counter is the base register, its value is read as the instruction address plus 8. When it is the store source, its value is read as the instruction address plus 12.

Top module: `hword_xfer_unit`

## Requirements
- R1: When `wb_en` is set and `base_idx` equals `rd_idx`, the unit raises `illegal` and `done` together one cycle after acceptance. It makes no memory request and no register write.
- R2: When `base_idx` is 15 (the program counter), the base value is `insn_addr + 8` and `base_val` is ignored.
- R3: The candidate address is the base plus `offset`, with 32-bit two's-complement wraparound.
- R4: With `pre_idx` = 1 the access uses the candidate address. With `pre_idx` = 0 it uses the unmodified base.
- R5: With `wb_en` set, the base register is written with the candidate address in both indexing modes. On a load, this write comes in the cycle after the data register write.
- R6: Type encoding is 01 = unsigned halfword (zero-extend 16 bits), 10 = signed byte (sign-extend `mem_rdata[7:0]`), 11 = signed halfword (sign-extend 16 bits) and 00 = reserved. Loads write the extended 32-bit value to `rd_idx`.
- R7: A load spends one internal cycle after the ready cycle. The data register is written exactly one cycle after `mem_ready` is seen. `done` is asserted one cycle after the last register write, or one cycle after ready for a store without writeback.
- R8: `flush` is high with `done` exactly when a load completes with `rd_idx` = 15. Otherwise it stays low.
- R9: A store drives `mem_we` = 1 and writes the low 16 bits of the source value. When `rd_idx` is 15, the source value is `insn_addr + 12`.
- R10: A store with a type other than 01, or a load with type 00, raises `type_err` and `done` one cycle after acceptance. It makes no memory request and no register write.
- R11: Once raised, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until the cycle in which `mem_ready` is seen.
- R12: `mem_size` is 0 (byte) for type 10 and 1 (halfword) for the other types.
- R13: After reset, `busy`, `mem_req`, `rf_we`, `done` and `flush` are low. A reset during an access withdraws the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Offer an instruction (taken when not busy) |
| is_load | input | 1 | 1 = load, 0 = store |
| pre_idx | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_en | input | 1 | Write the candidate address back to the base |
| xfer_type | input | 2 | Transfer type (see R6) |
| base_idx | input | 4 | Base register index |
| rd_idx | input | 4 | Data register index |
| insn_addr | input | 32 | Address of the instruction |
| base_val | input | 32 | Register-file value of the base |
| src_val | input | 32 | Register-file value of the data register |
| offset | input | 32 | Resolved signed offset |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write |
| mem_size | output | 1 | 0 = byte, 1 = halfword |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data |
| mem_ready | input | 1 | Access completes this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | Instruction complete (one cycle) |
| flush | output | 1 | Pipeline refetch required |
| illegal | output | 1 | Illegal base/destination writeback |
| type_err | output | 1 | Unsupported transfer type |

## Verification
The assertions assume that `start` is only raised while `busy` is low. They also assume that `mem_ready` is only driven high in a cycle where `mem_req` is high, and that the instruction fields are valid in the cycle `start` is accepted. The bench offers each instruction with a one-cycle `start` pulse and waits for `done` before the next. Its memory model raises `mem_ready` only against a visible request, after a per-vector delay of zero to two cycles. A reset is applied only while an access is still waiting, so no ready is ever returned without a request.

// File: rtl/hx_pkg.sv
// Shared types of the halfword/signed-byte transfer unit.
// Assumes the type encoding listed in the block brief.
package hx_pkg;
    typedef enum logic [1:0] {
        XT_RSV = 2'b00,
        XT_UH  = 2'b01,
        XT_SB  = 2'b10,
        XT_SH  = 2'b11
    } xfer_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACC  = 3'd1,
        ST_LEXT = 3'd2,
        ST_WBK  = 3'd3,
        ST_FIN  = 3'd4,
        ST_ERR  = 3'd5
    } hx_state_e;
endpackage

// File: rtl/hx_addr_gen.sv
// Address and store-value generation.
// Purely combinational. It assumes its inputs are the latched instruction
// fields. Program-counter reads are replaced by the instruction address plus
// the pipeline adjustment that applies to each use.
module hx_addr_gen #(
    parameter int XW        = 32,
    parameter int RIW       = 4,
    parameter int PC_IDX    = 15,
    parameter int PC_RD_ADJ = 8,
    parameter int PC_ST_ADJ = 12
) (
    input  logic [RIW-1:0] base_idx,
    input  logic [RIW-1:0] rd_idx,
    input  logic           pre_idx,
    input  logic [XW-1:0]  insn_addr,
    input  logic [XW-1:0]  base_val,
    input  logic [XW-1:0]  src_val,
    input  logic [XW-1:0]  offset,
    output logic [XW-1:0]  cand_addr,
    output logic [XW-1:0]  acc_addr,
    output logic [XW-1:0]  store_val
);
    localparam logic [RIW-1:0] PC_SEL = RIW'(PC_IDX);

    logic [XW-1:0] base_eff;

    // Select the effective base, add the offset and pick the access address.
    always_comb begin
        base_eff  = (base_idx == PC_SEL) ? insn_addr + XW'(PC_RD_ADJ) : base_val;
        cand_addr = base_eff + offset;
        acc_addr  = pre_idx ? cand_addr : base_eff;
        store_val = (rd_idx == PC_SEL) ? insn_addr + XW'(PC_ST_ADJ) : src_val;
    end
endmodule

// File: rtl/hx_load_ext.sv
// Load data extension.
// Widens the raw memory word to a register value according to the transfer
// type. It assumes the byte lane is the low byte of the returned halfword.
module hx_load_ext
    import hx_pkg::*;
#(
    parameter int XW = 32,
    parameter int MW = 16,
    parameter int BW = 8
) (
    input  logic [MW-1:0] raw,
    input  xfer_e         xtype,
    output logic [XW-1:0] ext
);
    // Choose zero or sign extension from the transfer type.
    always_comb begin
        unique case (xtype)
            XT_UH:   ext = {{(XW-MW){1'b0}}, raw};
            XT_SH:   ext = {{(XW-MW){raw[MW-1]}}, raw};
            XT_SB:   ext = {{(XW-BW){raw[BW-1]}}, raw[BW-1:0]};
            default: ext = '0;
        endcase
    end
endmodule

// File: rtl/hx_ctrl.sv
// Sequencer of the transfer unit.
// It screens each instruction at acceptance, holds the memory request until
// ready, inserts the internal cycle after load data, and orders the register
// writes: load result first, base writeback second. It assumes start is only
// offered while idle and that ready only comes while a request is up.
module hx_ctrl
    import hx_pkg::*;
#(
    parameter int RIW    = 4,
    parameter int PC_IDX = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           is_load,
    input  logic           wb_en,
    input  xfer_e          xtype,
    input  logic [RIW-1:0] base_idx,
    input  logic [RIW-1:0] rd_idx,
    input  logic           mem_ready,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic           ld_capture,
    output logic           rf_we,
    output logic           rf_sel_wb,
    output logic           done,
    output logic           flush,
    output logic           illegal,
    output logic           type_err
);
    localparam logic [RIW-1:0] PC_SEL = RIW'(PC_IDX);

    hx_state_e st, st_nxt;
    logic      ld_q, wb_q, rdpc_q, ill_q, terr_q;
    logic      accept, bad_wb, bad_type;

    // Screen the incoming instruction.
    always_comb begin
        accept   = start && (st == ST_IDLE);
        bad_wb   = wb_en && (base_idx == rd_idx);
        bad_type = is_load ? (xtype == XT_RSV) : (xtype != XT_UH);
    end

    // Next-state selection.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (accept) st_nxt = (bad_wb || bad_type) ? ST_ERR : ST_ACC;
            ST_ACC:  if (mem_ready) st_nxt = ld_q ? ST_LEXT : (wb_q ? ST_WBK : ST_FIN);
            ST_LEXT: st_nxt = wb_q ? ST_WBK : ST_FIN;
            ST_WBK:  st_nxt = ST_FIN;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Per-instruction flags captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q   <= 1'b0;
            wb_q   <= 1'b0;
            rdpc_q <= 1'b0;
            ill_q  <= 1'b0;
            terr_q <= 1'b0;
        end else if (accept) begin
            ld_q   <= is_load;
            wb_q   <= wb_en;
            rdpc_q <= (rd_idx == PC_SEL);
            ill_q  <= bad_wb;
            terr_q <= !bad_wb && bad_type;
        end
    end

    // Output decode from the state.
    always_comb begin
        busy       = (st != ST_IDLE);
        mem_req    = (st == ST_ACC);
        mem_we     = (st == ST_ACC) && !ld_q;
        ld_capture = (st == ST_ACC) && mem_ready && ld_q;
        rf_we      = (st == ST_LEXT) || (st == ST_WBK);
        rf_sel_wb  = (st == ST_WBK);
        done       = (st == ST_FIN) || (st == ST_ERR);
        flush      = (st == ST_FIN) && ld_q && rdpc_q;
        illegal    = (st == ST_ERR) && ill_q;
        type_err   = (st == ST_ERR) && terr_q;
    end

    // R1
    illegal_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad_wb) |=> (done && illegal && !mem_req && !rf_we));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req);

    // R7
    load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && ld_q) |=> (rf_we && !rf_sel_wb && !done));

    // R8
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (done && !illegal && !type_err));

    // R10
    type_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bad_wb && bad_type) |=> (done && type_err && !mem_req));
endmodule

// File: rtl/hword_xfer_unit.sv
// Halfword and signed-byte load/store unit (top).
// It latches the instruction fields on acceptance, generates addresses,
// extends load data and steers the single register-file write port. It
// assumes the fields are valid in the cycle start is accepted.
module hword_xfer_unit
    import hx_pkg::*;
#(
    parameter int XW        = 32,
    parameter int MW        = 16,
    parameter int RIW       = 4,
    parameter int PC_IDX    = 15,
    parameter int PC_RD_ADJ = 8,
    parameter int PC_ST_ADJ = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           is_load,
    input  logic           pre_idx,
    input  logic           wb_en,
    input  logic [1:0]     xfer_type,
    input  logic [RIW-1:0] base_idx,
    input  logic [RIW-1:0] rd_idx,
    input  logic [XW-1:0]  insn_addr,
    input  logic [XW-1:0]  base_val,
    input  logic [XW-1:0]  src_val,
    input  logic [XW-1:0]  offset,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_size,
    output logic [XW-1:0]  mem_addr,
    output logic [MW-1:0]  mem_wdata,
    input  logic [MW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic           rf_we,
    output logic [RIW-1:0] rf_waddr,
    output logic [XW-1:0]  rf_wdata,
    output logic           done,
    output logic           flush,
    output logic           illegal,
    output logic           type_err
);
    xfer_e          xtype_in, xtype_q;
    logic           pre_q, rf_sel_wb, ld_capture, accept;
    logic [RIW-1:0] base_q, rd_q;
    logic [XW-1:0]  ia_q, bv_q, sv_q, ofs_q;
    logic [XW-1:0]  cand_addr, acc_addr, store_val, ld_ext, ld_ext_q;

    assign xtype_in = xfer_e'(xfer_type);
    assign accept   = start && !busy;

    // Hold the instruction fields for the life of the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtype_q <= XT_RSV;
            pre_q   <= 1'b0;
            base_q  <= '0;
            rd_q    <= '0;
            ia_q    <= '0;
            bv_q    <= '0;
            sv_q    <= '0;
            ofs_q   <= '0;
        end else if (accept) begin
            xtype_q <= xtype_in;
            pre_q   <= pre_idx;
            base_q  <= base_idx;
            rd_q    <= rd_idx;
            ia_q    <= insn_addr;
            bv_q    <= base_val;
            sv_q    <= src_val;
            ofs_q   <= offset;
        end
    end

    hx_ctrl #(.RIW(RIW), .PC_IDX(PC_IDX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_load    (is_load),
        .wb_en      (wb_en),
        .xtype      (xtype_in),
        .base_idx   (base_idx),
        .rd_idx     (rd_idx),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .ld_capture (ld_capture),
        .rf_we      (rf_we),
        .rf_sel_wb  (rf_sel_wb),
        .done       (done),
        .flush      (flush),
        .illegal    (illegal),
        .type_err   (type_err)
    );

    hx_addr_gen #(
        .XW(XW), .RIW(RIW), .PC_IDX(PC_IDX),
        .PC_RD_ADJ(PC_RD_ADJ), .PC_ST_ADJ(PC_ST_ADJ)
    ) u_addr (
        .base_idx  (base_q),
        .rd_idx    (rd_q),
        .pre_idx   (pre_q),
        .insn_addr (ia_q),
        .base_val  (bv_q),
        .src_val   (sv_q),
        .offset    (ofs_q),
        .cand_addr (cand_addr),
        .acc_addr  (acc_addr),
        .store_val (store_val)
    );

    hx_load_ext #(.XW(XW), .MW(MW)) u_ext (
        .raw   (mem_rdata),
        .xtype (xtype_q),
        .ext   (ld_ext)
    );

    // Capture the extended load data in the ready cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          ld_ext_q <= '0;
        else if (ld_capture) ld_ext_q <= ld_ext;
    end

    // Drive the memory port and the register-file write port.
    always_comb begin
        mem_addr  = acc_addr;
        mem_wdata = store_val[MW-1:0];
        mem_size  = (xtype_q != XT_SB);
        rf_waddr  = rf_sel_wb ? base_q : rd_q;
        rf_wdata  = rf_sel_wb ? cand_addr : ld_ext_q;
    end

    // R11
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!mem_req && !done));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !done));
endmodule

// File: tb/hword_xfer_unit_bench.sv
`timescale 1ns/1ps
module hword_xfer_unit_bench;
    typedef struct packed {
        logic        ld;
        logic        pre;
        logic        wb;
        logic [1:0]  typ;
        logic [3:0]  bi;
        logic [3:0]  ri;
        logic [31:0] ia;
        logic [31:0] bv;
        logic [31:0] sv;
        logic [31:0] ofs;
        logic [15:0] rdat;
        logic [1:0]  dly;
    } vec_t;

    // Vectors: load/store mixes, both index modes, PC as base and as data,
    // the illegal writeback case and each rejected type.
    localparam vec_t VT [12] = '{
        '{1'b1,1'b1,1'b0,2'b11,4'd2, 4'd1, 32'h40, 32'h1000,     32'h0,        32'h4,        16'h8001,2'd0},
        '{1'b1,1'b0,1'b1,2'b10,4'd3, 4'd1, 32'h40, 32'h2000,     32'h0,        32'hFFFFFFFE, 16'h12F0,2'd2},
        '{1'b1,1'b1,1'b1,2'b01,4'd4, 4'd2, 32'h40, 32'h300,      32'h0,        32'h10,       16'h8001,2'd0},
        '{1'b0,1'b1,1'b0,2'b01,4'd5, 4'd6, 32'h40, 32'h400,      32'hABCD1234, 32'h0,        16'h0,   2'd1},
        '{1'b0,1'b0,1'b1,2'b01,4'd6, 4'd5, 32'h40, 32'hFFFFFFFE, 32'h00005A5A, 32'h4,        16'h0,   2'd0},
        '{1'b1,1'b1,1'b0,2'b10,4'd15,4'd3, 32'h80, 32'hDEAD0000, 32'h0,        32'h1,        16'h007F,2'd1},
        '{1'b0,1'b1,1'b0,2'b01,4'd1, 4'd15,32'h100,32'h500,      32'h0,        32'h2,        16'h0,   2'd0},
        '{1'b1,1'b1,1'b0,2'b01,4'd2, 4'd15,32'h40, 32'h600,      32'h0,        32'h0,        16'hBEEF,2'd0},
        '{1'b1,1'b1,1'b1,2'b01,4'd7, 4'd7, 32'h40, 32'h700,      32'h0,        32'h0,        16'h0,   2'd0},
        '{1'b0,1'b1,1'b0,2'b10,4'd1, 4'd2, 32'h40, 32'h800,      32'h0,        32'h0,        16'h0,   2'd0},
        '{1'b0,1'b1,1'b0,2'b11,4'd1, 4'd2, 32'h40, 32'h800,      32'h0,        32'h0,        16'h0,   2'd0},
        '{1'b1,1'b1,1'b0,2'b00,4'd1, 4'd2, 32'h40, 32'h800,      32'h0,        32'h0,        16'h0,   2'd0}
    };

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic        is_load = 1'b0, pre_idx = 1'b0, wb_en = 1'b0;
    logic [1:0]  xfer_type = 2'b00;
    logic [3:0]  base_idx = '0, rd_idx = '0;
    logic [31:0] insn_addr = '0, base_val = '0, src_val = '0, offset = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, mem_req, mem_we, mem_size, rf_we, done, flush, illegal, type_err;
    logic [31:0] mem_addr, rf_wdata;
    logic [15:0] mem_wdata;
    logic [3:0]  rf_waddr;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    hword_xfer_unit u_hword_xfer_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load), .pre_idx(pre_idx),
        .wb_en(wb_en), .xfer_type(xfer_type), .base_idx(base_idx), .rd_idx(rd_idx),
        .insn_addr(insn_addr), .base_val(base_val), .src_val(src_val), .offset(offset),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .done(done), .flush(flush), .illegal(illegal), .type_err(type_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic offer(input vec_t v);
        @(negedge clk);
        is_load = v.ld; pre_idx = v.pre; wb_en = v.wb; xfer_type = v.typ;
        base_idx = v.bi; rd_idx = v.ri; insn_addr = v.ia; base_val = v.bv;
        src_val = v.sv; offset = v.ofs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input int k, input vec_t v);
        logic [31:0] base, cand, acc, sval, ext;
        bit          bad_wb, bad_ty, seen, moved, got_done;
        logic [31:0] r_addr; logic [15:0] r_wdat; logic r_we, r_sz;
        int          cyc, rdy_cyc, done_cyc, nw, wait_n;
        logic [3:0]  w_idx [2]; logic [31:0] w_dat [2]; int w_cyc [2];
        logic        f_flush, f_ill, f_terr;
        string       areq;
        // Expected values from the requirements.
        base   = (v.bi == 4'd15) ? v.ia + 32'd8 : v.bv;
        cand   = base + v.ofs;
        acc    = v.pre ? cand : base;
        sval   = (v.ri == 4'd15) ? v.ia + 32'd12 : v.sv;
        bad_wb = v.wb && (v.bi == v.ri);
        bad_ty = v.ld ? (v.typ == 2'b00) : (v.typ != 2'b01);
        case (v.typ)
            2'b01:   ext = {16'h0, v.rdat};
            2'b10:   ext = {{24{v.rdat[7]}}, v.rdat[7:0]};
            2'b11:   ext = {{16{v.rdat[15]}}, v.rdat};
            default: ext = '0;
        endcase
        areq = (v.bi == 4'd15) ? "R2" : (v.pre ? "R3" : "R4");
        seen = 0; moved = 0; got_done = 0; cyc = 0; rdy_cyc = -1; done_cyc = -1;
        nw = 0; wait_n = 0; r_addr = '0; r_wdat = '0; r_we = 0; r_sz = 0;
        f_flush = 0; f_ill = 0; f_terr = 0;
        for (int i = 0; i < 2; i++) begin w_idx[i] = '0; w_dat[i] = '0; w_cyc[i] = -1; end
        offer(v);
        for (int t = 0; t < 40 && !got_done; t++) begin
            cyc++;
            mem_ready = 1'b0;
            if (mem_req) begin
                if (!seen) begin
                    seen = 1; r_addr = mem_addr; r_we = mem_we; r_sz = mem_size; r_wdat = mem_wdata;
                end else if (mem_addr != r_addr || mem_we != r_we || mem_wdata != r_wdat) begin
                    moved = 1;
                end
                if (wait_n == int'(v.dly)) begin
                    mem_ready = 1'b1; mem_rdata = v.rdat; rdy_cyc = cyc;
                end else begin
                    wait_n++;
                end
            end
            if (rf_we) begin
                if (nw < 2) begin w_idx[nw] = rf_waddr; w_dat[nw] = rf_wdata; w_cyc[nw] = cyc; end
                nw++;
            end
            if (done) begin
                got_done = 1; done_cyc = cyc; f_flush = flush; f_ill = illegal; f_terr = type_err;
            end
            if (!got_done) @(negedge clk);
        end
        mem_ready = 1'b0;
        chk(got_done, "R7", $sformatf("vec%0d done seen", k), 32'(got_done), 32'd1);
        if (bad_wb || bad_ty) begin
            if (bad_wb) chk(f_ill && !f_terr && done_cyc == 1 && !seen && nw == 0, "R1",
                            $sformatf("vec%0d illegal/cycle", k), 32'(done_cyc), 32'd1);
            else        chk(f_terr && !f_ill && done_cyc == 1 && !seen && nw == 0, "R10",
                            $sformatf("vec%0d type_err/cycle", k), 32'(done_cyc), 32'd1);
            return;
        end
        chk(seen && r_addr == acc, areq, $sformatf("vec%0d access address", k), r_addr, acc);
        chk(r_we == !v.ld, "R9", $sformatf("vec%0d write strobe", k), 32'(r_we), 32'(!v.ld));
        chk(r_sz == (v.typ != 2'b10), "R12", $sformatf("vec%0d size", k), 32'(r_sz), 32'(v.typ != 2'b10));
        chk(!moved, "R11", $sformatf("vec%0d request held", k), 32'(moved), 32'd0);
        chk(f_flush == (v.ld && v.ri == 4'd15), "R8", $sformatf("vec%0d flush", k),
            32'(f_flush), 32'(v.ld && v.ri == 4'd15));
        chk(!f_ill && !f_terr, "R1", $sformatf("vec%0d no error", k), 32'({f_ill, f_terr}), 32'd0);
        if (v.ld) begin
            chk(w_idx[0] == v.ri && w_dat[0] == ext, "R6", $sformatf("vec%0d load data", k), w_dat[0], ext);
            chk(w_cyc[0] == rdy_cyc + 1, "R7", $sformatf("vec%0d load write cycle", k),
                32'(w_cyc[0]), 32'(rdy_cyc + 1));
            if (v.wb) begin
                chk(nw == 2 && w_idx[1] == v.bi && w_dat[1] == cand && w_cyc[1] == rdy_cyc + 2, "R5",
                    $sformatf("vec%0d writeback after load", k), w_dat[1], cand);
            end else begin
                chk(nw == 1, "R5", $sformatf("vec%0d no writeback", k), 32'(nw), 32'd1);
            end
            chk(done_cyc == rdy_cyc + (v.wb ? 3 : 2), "R7", $sformatf("vec%0d done cycle", k),
                32'(done_cyc), 32'(rdy_cyc + (v.wb ? 3 : 2)));
        end else begin
            chk(r_wdat == sval[15:0], "R9", $sformatf("vec%0d store data", k), 32'(r_wdat), 32'(sval[15:0]));
            if (v.wb) chk(nw == 1 && w_idx[0] == v.bi && w_dat[0] == cand && w_cyc[0] == rdy_cyc + 1, "R5",
                          $sformatf("vec%0d store writeback", k), w_dat[0], cand);
            else      chk(nw == 0, "R5", $sformatf("vec%0d store no write", k), 32'(nw), 32'd0);
            chk(done_cyc == rdy_cyc + (v.wb ? 2 : 1), "R7", $sformatf("vec%0d store done cycle", k),
                32'(done_cyc), 32'(rdy_cyc + (v.wb ? 2 : 1)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !mem_req && !rf_we && !done && !flush, "R13", "state in reset",
            32'({busy, mem_req, rf_we, done, flush}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !rf_we && !done && !flush, "R13", "idle after reset",
            32'({busy, mem_req, rf_we, done, flush}), 32'd0);
        for (int k = 0; k < 12; k++) run_vec(k, VT[k]);
        // R13: reset while a request waits for ready
        offer(VT[0]);
        @(negedge clk);
        chk(mem_req, "R13", "request pending before reset", 32'(mem_req), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_req && !busy, "R13", "request withdrawn by reset", 32'({mem_req, busy}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: PC base with post-index writeback, then normal op afterwards
        run_vec(12, '{1'b0,1'b0,1'b1,2'b01,4'd15,4'd4,32'h200,32'h0,32'h1111,32'hFFFFFFF0,16'h0,2'd1});
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule